// File: doc/BRIEF.md
# Character Display Data RAM Access Path

This block is the memory-access side of a character display controller. It owns two byte memories, a 128-entry text store and a 64-entry glyph store. One shared address counter points into whichever store the last address command chose. A host reaches the block over a byte bus with a register-select line and a read/write line. Through that bus it can read a status byte, write a data byte or read a data byte.

Host data reads are not served from memory directly. They return a one-byte read buffer that the block fills ahead of time. An address command fills this buffer, as does a cursor move on the text store and each data read. A data write moves the counter but leaves the buffer alone, so the first read after a write, or after reset, returns an old byte. A flag that travels with the read data marks such bytes.

Every accepted command or data access holds a busy flag high for a fixed number of clock cycles. Anything that arrives during that window is dropped, except a status read. Three single-cycle command inputs come from the instruction decoder: address set, entry direction and cursor shift.

Top module: `charram_access`

## Requirements
- R1: A status read (`bus_sel`=0, `bus_rd`=1) is answered even while busy. On the next cycle it returns bit 7 = busy and bits 6..0 = address counter, with `bus_rvalid` high. It does not start a busy window.
- R2: A data write (`bus_sel`=1, `bus_rd`=0) stores `bus_wdata` at the counter's address in the selected store, then steps the counter by one.
- R3: A data read (`bus_sel`=1, `bus_rd`=1) returns the read buffer on the next cycle. `bus_rfresh` gives the buffer's valid flag. The counter then steps by one and the buffer is refilled from the new address with the flag set.
- R4: An address command selects the glyph store when `cmd_addr_glyph`=1 and the text store when it is 0. It loads the counter and refills the read buffer from that address with the valid flag set. For the glyph store only the low six address bits are kept and bit 6 is 0.
- R5: A data write does not refill the read buffer and clears its valid flag. The next data read returns the byte held before the write, with `bus_rfresh`=0.
- R6: An entry command sets the step direction: `cmd_entry_up`=1 counts up and 0 counts down. Data reads and writes step in that direction.
- R7: The counter wraps modulo 128 while the text store is selected and modulo 64 while the glyph store is selected.
- R8: A cursor shift moves the counter by one, up when `cmd_shift_right`=1 and down otherwise. With the text store selected it refills the read buffer from the new address. With the glyph store selected it leaves the buffer and its flag unchanged.
- R9: Every accepted command or data access holds `busy` high for exactly BUSY_CYC cycles, starting in the cycle after acceptance.
- R10: While `busy` is high, every data access and command is ignored; the only exception is a status read. A control write (`bus_sel`=0, `bus_rd`=0) is always ignored and starts no busy window.
- R11: After reset the counter is 0, the text store is selected, the direction is up and `busy` is low. The read buffer holds 0x00 with its valid flag clear.
- R12: When several requests arrive in one idle cycle, only one is taken. Address set wins over cursor shift, cursor shift over entry command, and the entry command over a host data access. The others are dropped.
- R13: Writes to one store never change the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Host access strobe, one cycle per access |
| bus_sel | input | 1 | Register select: 0 status/control, 1 data |
| bus_rd | input | 1 | 1 read, 0 write |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Read result, updated the cycle after a read |
| bus_rvalid | output | 1 | Pulses with each read result |
| bus_rfresh | output | 1 | Read result came from a valid buffer |
| cmd_addr_valid | input | 1 | Address-set command pulse |
| cmd_addr_glyph | input | 1 | Address command targets the glyph store |
| cmd_addr | input | 7 | Address to load into the counter |
| cmd_entry_valid | input | 1 | Entry-direction command pulse |
| cmd_entry_up | input | 1 | New step direction, 1 = up |
| cmd_shift_valid | input | 1 | Cursor-shift command pulse |
| cmd_shift_right | input | 1 | Shift direction, 1 = up |
| busy | output | 1 | Internal operation in progress |

## Verification
The assertions assume that every request input is a one-cycle pulse and that inputs are quiet during reset. They also assume BUSY_CYC is at least 2, so a refill of the read buffer lands before busy drops. The bench drives each request for one cycle from the falling edge and waits for busy to clear before each normal access. It breaks that rule only on purpose: once inside a busy window, and once to send competing requests in the same cycle. Store contents after reset are undefined, so the bench reads back only addresses it has written first.

// File: rtl/charram_pkg.sv
package charram_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_ADDR,
    OP_SHIFT,
    OP_ENTRY,
    OP_WRITE,
    OP_READ
  } charram_op_e;
endpackage

// File: rtl/charram_mem.sv
module charram_mem #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  // Synchronous write and registered read, suitable for block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/charram_addr_ctr.sv
module charram_addr_ctr #(
  parameter int AW  = 7,
  parameter int GAW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic          ld_glyph,
  input  logic [AW-1:0] ld_addr,
  input  logic          step_en,
  input  logic          step_up,
  input  logic          dir_we,
  input  logic          dir_up_in,
  output logic [AW-1:0] ac,
  output logic          glyph_sel,
  output logic          dir_up
);
  localparam logic [AW-1:0] GMASK = AW'((1 << GAW) - 1);

  logic [AW-1:0] stepped;

  always_comb begin
    stepped = step_up ? ac + AW'(1) : ac - AW'(1);
    if (glyph_sel) stepped = stepped & GMASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ac        <= '0;
      glyph_sel <= 1'b0;
      dir_up    <= 1'b1;
    end else begin
      if (ld_en) begin
        ac        <= ld_glyph ? (ld_addr & GMASK) : ld_addr;
        glyph_sel <= ld_glyph;
      end else if (step_en) begin
        ac <= stepped;
      end
      if (dir_we) dir_up <= dir_up_in;
    end
  end
endmodule

// File: rtl/charram_busy_timer.sv
module charram_busy_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (start)      cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/charram_access.sv
module charram_access
  import charram_pkg::*;
#(
  parameter int TEXT_AW  = 7,
  parameter int GLYPH_AW = 6,
  parameter int DW       = 8,
  parameter int BUSY_CYC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_valid,
  input  logic               bus_sel,
  input  logic               bus_rd,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               bus_rvalid,
  output logic               bus_rfresh,
  input  logic               cmd_addr_valid,
  input  logic               cmd_addr_glyph,
  input  logic [TEXT_AW-1:0] cmd_addr,
  input  logic               cmd_entry_valid,
  input  logic               cmd_entry_up,
  input  logic               cmd_shift_valid,
  input  logic               cmd_shift_right,
  output logic               busy
);
  charram_op_e        cur_op;
  logic [TEXT_AW-1:0] ac_q;
  logic               glyph_q;
  logic               dir_up_q;
  logic               status_rd;
  logic [DW-1:0]      status_w;
  logic               fetch_pend, fetch_dly, fetch_glyph;
  logic [DW-1:0]      text_q, glyph_q_data;
  logic [DW-1:0]      obuf_q;
  logic               obuf_ok_q;

  // Only one request is taken per idle cycle, in fixed priority order.
  always_comb begin
    cur_op = OP_NONE;
    if (!busy) begin
      if (cmd_addr_valid)             cur_op = OP_ADDR;
      else if (cmd_shift_valid)       cur_op = OP_SHIFT;
      else if (cmd_entry_valid)       cur_op = OP_ENTRY;
      else if (bus_valid && bus_sel)  cur_op = bus_rd ? OP_READ : OP_WRITE;
    end
  end

  assign status_rd = bus_valid && !bus_sel && bus_rd;

  always_comb begin
    status_w = '0;
    status_w[DW-1] = busy;
    status_w[TEXT_AW-1:0] = ac_q;
  end

  charram_addr_ctr #(.AW(TEXT_AW), .GAW(GLYPH_AW)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .ld_en     (cur_op == OP_ADDR),
    .ld_glyph  (cmd_addr_glyph),
    .ld_addr   (cmd_addr),
    .step_en   (cur_op == OP_SHIFT || cur_op == OP_READ || cur_op == OP_WRITE),
    .step_up   ((cur_op == OP_SHIFT) ? cmd_shift_right : dir_up_q),
    .dir_we    (cur_op == OP_ENTRY),
    .dir_up_in (cmd_entry_up),
    .ac        (ac_q),
    .glyph_sel (glyph_q),
    .dir_up    (dir_up_q)
  );

  charram_busy_timer #(.CYC(BUSY_CYC)) u_busy (
    .clk   (clk),
    .rst   (rst),
    .start (cur_op != OP_NONE),
    .busy  (busy)
  );

  charram_mem #(.AW(TEXT_AW), .DW(DW)) u_text (
    .clk   (clk),
    .we    (cur_op == OP_WRITE && !glyph_q),
    .waddr (ac_q),
    .wdata (bus_wdata),
    .re    (fetch_pend),
    .raddr (ac_q),
    .rdata (text_q)
  );

  charram_mem #(.AW(GLYPH_AW), .DW(DW)) u_glyph (
    .clk   (clk),
    .we    (cur_op == OP_WRITE && glyph_q),
    .waddr (ac_q[GLYPH_AW-1:0]),
    .wdata (bus_wdata),
    .re    (fetch_pend),
    .raddr (ac_q[GLYPH_AW-1:0]),
    .rdata (glyph_q_data)
  );

  // Prefetch pipeline: request after the counter settles, read, then latch.
  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pend  <= 1'b0;
      fetch_dly   <= 1'b0;
      fetch_glyph <= 1'b0;
    end else begin
      fetch_pend  <= (cur_op == OP_ADDR) || (cur_op == OP_READ) ||
                     (cur_op == OP_SHIFT && !glyph_q);
      fetch_dly   <= fetch_pend;
      fetch_glyph <= glyph_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      obuf_q    <= '0;
      obuf_ok_q <= 1'b0;
    end else if (fetch_dly) begin
      obuf_q    <= fetch_glyph ? glyph_q_data : text_q;
      obuf_ok_q <= 1'b1;
    end else if (cur_op == OP_WRITE) begin
      obuf_ok_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_rfresh <= 1'b0;
    end else begin
      bus_rvalid <= status_rd || (cur_op == OP_READ);
      if (status_rd) begin
        bus_rdata  <= status_w;
        bus_rfresh <= 1'b1;
      end else if (cur_op == OP_READ) begin
        bus_rdata  <= obuf_q;
        bus_rfresh <= obuf_ok_q;
      end
    end
  end
endmodule

// File: rtl/charram_access_chk.sv
module charram_access_chk #(
  parameter int TEXT_AW  = 7,
  parameter int GLYPH_AW = 6,
  parameter int DW       = 8,
  parameter int BUSY_CYC = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_valid,
  input logic               bus_sel,
  input logic               bus_rd,
  input logic               cmd_addr_valid,
  input logic               cmd_entry_valid,
  input logic               cmd_shift_valid,
  input logic               busy,
  input logic [DW-1:0]      bus_rdata,
  input logic               bus_rvalid,
  input logic [TEXT_AW-1:0] ac,
  input logic               glyph_sel,
  input logic               dir_up,
  input logic               obuf_ok
);
  localparam int RW = $clog2(BUSY_CYC + 2);

  logic [RW-1:0] run;
  logic          data_go;

  assign data_go = !busy && bus_valid && bus_sel &&
                   !cmd_addr_valid && !cmd_entry_valid && !cmd_shift_valid;

  always_ff @(posedge clk) begin
    if (rst)       run <= '0;
    else if (busy) run <= run + RW'(1);
    else           run <= '0;
  end

  // R1: status byte carries the previous cycle's busy flag and counter
  p_status_fmt_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_sel && bus_rd) |=> (bus_rvalid &&
      bus_rdata[DW-1] == $past(busy) && bus_rdata[TEXT_AW-1:0] == $past(ac)));

  // R9: busy window never exceeds its length
  p_busy_max_r9: assert property (@(posedge clk) disable iff (rst)
    run <= RW'(BUSY_CYC));

  // R9: a busy window ends only after its full length
  p_busy_len_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run == RW'(BUSY_CYC));

  // R10: nothing moves the counter or store selection while busy
  p_busy_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(ac) && $stable(glyph_sel)));

  // R5: an accepted write invalidates the read buffer
  p_write_stale_r5: assert property (@(posedge clk) disable iff (rst)
    (data_go && !bus_rd) |=> !obuf_ok);

  // R2: text store, counting up, moves the counter by one
  p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
    (data_go && !glyph_sel && dir_up) |=> ac == $past(ac) + TEXT_AW'(1));

  // R7: glyph store keeps the counter inside 64 entries
  p_glyph_range_r7: assert property (@(posedge clk) disable iff (rst)
    glyph_sel |-> ac[TEXT_AW-1:GLYPH_AW] == '0);

  // R3: read results appear only after a read request
  p_rvalid_cause_r3: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_valid && bus_rd));
endmodule

bind charram_access charram_access_chk #(
  .TEXT_AW(TEXT_AW), .GLYPH_AW(GLYPH_AW), .DW(DW), .BUSY_CYC(BUSY_CYC)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .bus_valid       (bus_valid),
  .bus_sel         (bus_sel),
  .bus_rd          (bus_rd),
  .cmd_addr_valid  (cmd_addr_valid),
  .cmd_entry_valid (cmd_entry_valid),
  .cmd_shift_valid (cmd_shift_valid),
  .busy            (busy),
  .bus_rdata       (bus_rdata),
  .bus_rvalid      (bus_rvalid),
  .ac              (ac_q),
  .glyph_sel       (glyph_q),
  .dir_up          (dir_up_q),
  .obuf_ok         (obuf_ok_q)
);

// File: tb/tb_charram_access.sv
module tb_charram_access;
  localparam int CLK_P = 10;
  localparam int BUSY_CYC = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_valid = 0, bus_sel = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid, bus_rfresh;
  logic       cmd_addr_valid = 0, cmd_addr_glyph = 0;
  logic [6:0] cmd_addr = 0;
  logic       cmd_entry_valid = 0, cmd_entry_up = 0;
  logic       cmd_shift_valid = 0, cmd_shift_right = 0;
  logic       busy;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  charram_access #(.BUSY_CYC(BUSY_CYC)) dut (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bus_rfresh(bus_rfresh),
    .cmd_addr_valid(cmd_addr_valid), .cmd_addr_glyph(cmd_addr_glyph),
    .cmd_addr(cmd_addr),
    .cmd_entry_valid(cmd_entry_valid), .cmd_entry_up(cmd_entry_up),
    .cmd_shift_valid(cmd_shift_valid), .cmd_shift_right(cmd_shift_right),
    .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // Raw one-cycle host access with no wait for idle.
  task automatic bus_raw(input logic sel, input logic rd, input logic [7:0] wd);
    bus_valid = 1; bus_sel = sel; bus_rd = rd; bus_wdata = wd;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic bus_op(input logic sel, input logic rd, input logic [7:0] wd);
    wait_idle();
    bus_raw(sel, rd, wd);
  endtask

  task automatic status(output logic [7:0] v);
    bus_op(1'b0, 1'b1, 8'h00);
    v = bus_rdata;
  endtask

  task automatic rd_data(output logic [7:0] v, output logic f);
    bus_op(1'b1, 1'b1, 8'h00);
    v = bus_rdata; f = bus_rfresh;
  endtask

  task automatic wr_data(input logic [7:0] d);
    bus_op(1'b1, 1'b0, d);
  endtask

  task automatic set_addr(input logic g, input logic [6:0] a);
    wait_idle();
    cmd_addr_valid = 1; cmd_addr_glyph = g; cmd_addr = a;
    @(negedge clk);
    cmd_addr_valid = 0;
  endtask

  task automatic entry(input logic up);
    wait_idle();
    cmd_entry_valid = 1; cmd_entry_up = up;
    @(negedge clk);
    cmd_entry_valid = 0;
  endtask

  task automatic shift(input logic right);
    wait_idle();
    cmd_shift_valid = 1; cmd_shift_right = right;
    @(negedge clk);
    cmd_shift_valid = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v; logic f;
    chk(busy == 1'b0, "R11 busy after reset", busy, 0);
    status(v);
    chk(v == 8'h00, "R11 R1 status after reset", v, 8'h00);
    rd_data(v, f);
    chk(v == 8'h00, "R11 buffer after reset", v, 8'h00);
    chk(f == 1'b0, "R11 buffer flag after reset", f, 0);
  endtask

  task automatic t_write_read();
    logic [7:0] v; logic f;
    set_addr(1'b0, 7'h20);
    wr_data(8'h11); wr_data(8'h22); wr_data(8'h33); wr_data(8'h44); wr_data(8'h66);
    status(v);
    chk(v == 8'h25, "R2 counter after writes", v, 8'h25);
    set_addr(1'b0, 7'h20);
    rd_data(v, f);
    chk(v == 8'h11 && f, "R4 R3 read after address set", v, 8'h11);
    rd_data(v, f);
    chk(v == 8'h22 && f, "R3 second read", v, 8'h22);
  endtask

  task automatic t_stale();
    logic [7:0] v; logic f;
    wr_data(8'h55);
    rd_data(v, f);
    chk(v == 8'h33, "R5 read after write returns old byte", v, 8'h33);
    chk(f == 1'b0, "R5 stale flag", f, 0);
    rd_data(v, f);
    chk(v == 8'h66 && f, "R3 following read correct", v, 8'h66);
  endtask

  task automatic t_down();
    logic [7:0] v; logic f;
    entry(1'b0);
    set_addr(1'b0, 7'h22);
    rd_data(v, f);
    chk(v == 8'h55, "R6 read at start", v, 8'h55);
    rd_data(v, f);
    chk(v == 8'h22, "R6 read after down step", v, 8'h22);
    status(v);
    chk(v == 8'h20, "R6 counter counts down", v, 8'h20);
    entry(1'b1);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    set_addr(1'b0, 7'h7F);
    wr_data(8'h77);
    status(v);
    chk(v == 8'h00, "R7 text wrap up", v, 8'h00);
    entry(1'b0);
    set_addr(1'b0, 7'h00);
    wr_data(8'h78);
    status(v);
    chk(v == 8'h7F, "R7 text wrap down", v, 8'h7F);
    entry(1'b1);
  endtask

  task automatic t_glyph();
    logic [7:0] v; logic f;
    set_addr(1'b1, 7'h3E);
    wr_data(8'hA1); wr_data(8'hA2); wr_data(8'hA3);
    status(v);
    chk(v == 8'h01, "R7 glyph wrap", v, 8'h01);
    set_addr(1'b1, 7'h20);
    wr_data(8'hEE);
    set_addr(1'b0, 7'h20);
    rd_data(v, f);
    chk(v == 8'h11, "R13 text store untouched by glyph write", v, 8'h11);
    set_addr(1'b1, 7'h3F);
    rd_data(v, f);
    chk(v == 8'hA2 && f, "R4 glyph read", v, 8'hA2);
  endtask

  task automatic t_shift();
    logic [7:0] v; logic f;
    set_addr(1'b0, 7'h23);
    wr_data(8'h45);
    shift(1'b0);
    rd_data(v, f);
    chk(v == 8'h45 && f, "R8 text shift refills buffer", v, 8'h45);
    shift(1'b1);
    status(v);
    chk(v == 8'h25, "R8 shift right moves counter", v, 8'h25);
    set_addr(1'b1, 7'h3F);
    shift(1'b1);
    status(v);
    chk(v == 8'h00, "R8 R7 glyph shift wraps", v, 8'h00);
    rd_data(v, f);
    chk(v == 8'hA2, "R8 glyph shift keeps buffer", v, 8'hA2);
  endtask

  task automatic t_busy();
    logic [7:0] v; logic f; int n;
    set_addr(1'b0, 7'h30);
    wr_data(8'h5A);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == BUSY_CYC, "R9 busy length", n, BUSY_CYC);
    set_addr(1'b0, 7'h30);
    wr_data(8'h5B);
    bus_raw(1'b1, 1'b0, 8'hC3);
    bus_raw(1'b0, 1'b1, 8'h00);
    chk(bus_rdata == 8'hB1, "R1 R10 status while busy", bus_rdata, 8'hB1);
    status(v);
    chk(v == 8'h31, "R10 write while busy ignored", v, 8'h31);
    bus_op(1'b0, 1'b0, 8'h12);
    chk(busy == 1'b0, "R10 control write starts no busy", busy, 0);
    status(v);
    chk(v == 8'h31, "R10 control write leaves counter", v, 8'h31);
    set_addr(1'b0, 7'h30);
    rd_data(v, f);
    chk(v == 8'h5B, "R10 stored byte not overwritten", v, 8'h5B);
  endtask

  task automatic t_priority();
    logic [7:0] v; logic f;
    wait_idle();
    cmd_addr_valid = 1; cmd_addr_glyph = 0; cmd_addr = 7'h30;
    bus_valid = 1; bus_sel = 1; bus_rd = 0; bus_wdata = 8'hFF;
    @(negedge clk);
    cmd_addr_valid = 0; bus_valid = 0;
    status(v);
    chk(v == 8'h30, "R12 address set wins, write dropped", v, 8'h30);
    rd_data(v, f);
    chk(v == 8'h5B, "R12 dropped write did not store", v, 8'h5B);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_stale();
    t_down();
    t_wrap();
    t_glyph();
    t_shift();
    t_busy();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule